// File: doc/BRIEF.md
# Dual Timer/Counter Channel Pair

This block holds two 16-bit count channels that share one byte-wide register port. Each channel adds one to its count either on an internal clock-enable tick or on each falling edge seen on its own event pin. A four-bit configuration nibble per channel chooses the counting structure, whether an external gate pin qualifies counting, and which source is counted. A shared control byte holds one run bit and one overflow flag per channel.

When a channel's count wraps to zero, its overflow flag is raised and driven out to an interrupt controller. That controller returns a one-cycle acknowledge pulse per channel, and the pulse clears the matching flag. Software can also read and write the flags, the run bits, the configuration byte and all four count bytes through the register port.

Channel 0 has one more structure: it can be split into two independent 8-bit counters. In that case its high byte counts internal ticks under channel 1's run bit and raises channel 1's flag.

Top module: `dual_timer_counter`

## Requirements
- R1: After reset, every readable register reads 0x00 and both overflow outputs are low.
- R2: Register port, with combinational reads. Address 0 is the configuration byte: bits 7:4 are channel 1 and bits 3:0 are channel 0, each nibble ordered gate, event-source select, mode high bit, mode low bit from MSB down. Address 1 is the control byte: bit 7 is the channel 1 flag, bit 6 the channel 1 run bit, bit 5 the channel 0 flag, bit 4 the channel 0 run bit, and bits 3:0 read as zero. Addresses 2/3 are channel 0 low/high and 4/5 are channel 1 low/high. A write to a count byte lands on the next clock edge and overrides an increment of that byte in the same cycle.
- R3: Mode 1 counts the full 16-bit value {high, low}. The step from 0xFFFF to 0x0000 sets the channel's flag.
- R4: Mode 0 counts a 13-bit value formed by the high byte above the low 5 bits of the low byte. The upper 3 bits of the low byte keep their value. Wrapping from all ones sets the flag.
- R5: Mode 2 counts only the low byte. When the low byte is at 0xFF, the next count loads it from the high byte and sets the flag.
- R6: Mode 3 on channel 0 makes two 8-bit counters. The low byte uses channel 0's run, gate and source and sets channel 0's flag. The high byte counts internal ticks while channel 1's run bit is set, and its wrap sets channel 1's flag.
- R7: Mode 3 on channel 1 freezes both of its count bytes.
- R8: Clearing a run bit stops counting and keeps the count. Setting it again resumes counting from the held value.
- R9: With the gate bit set, a channel counts only while its gate pin, after a two-flop synchronizer, is high. With the gate bit clear, only the run bit qualifies counting.
- R10: With the source-select bit set, a channel counts each high-to-low change of its synchronized event pin once, and internal ticks have no effect.
- R11: An acknowledge pulse clears only the flag of its own channel.
- R12: A counter wrap in the same cycle as a software write or an acknowledge of that flag leaves the flag set.
- R13: A control-byte write loads both flags from the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal count tick (clock enable) |
| ev_pin | input | 2 | Per-channel external event pins (asynchronous) |
| gate_pin | input | 2 | Per-channel gate qualifier pins (asynchronous) |
| irq_ack | input | 2 | Per-channel overflow acknowledge pulses |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ovf_flag | output | 2 | Per-channel overflow flags |

## Verification
The embedded properties check on every cycle how the overflow flag resolves its sources: a wrap always sets it, an acknowledge alone clears it, and a control write loads it. They also check that a count holds when it is halted, gated off, frozen in mode 3 on channel 1, or in event mode with no edge, that a mode 2 wrap loads the reload value, and that an event pulse lasts a single cycle. Only the bench scenarios can show the actual arithmetic of each mode from chosen start values. The same holds for the untouched upper low-byte bits in mode 0, the split-mode high byte raising the other channel's flag, synchronizer latency, and the register map as software sees it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      MODE_13     = 2'd0,
      MODE_16     = 2'd1,
      MODE_RELOAD = 2'd2,
      MODE_SPLIT  = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic      gate;
      logic      ext_src;
      tmr_mode_e mode;
   } tmr_cfg_t;

   localparam int CFG_W = 4;

   localparam logic [2:0] ADDR_MODE  = 3'd0;
   localparam logic [2:0] ADDR_CTRL  = 3'd1;
   localparam logic [2:0] ADDR_C0_LO = 3'd2;
   localparam logic [2:0] ADDR_C0_HI = 3'd3;
   localparam logic [2:0] ADDR_C1_LO = 3'd4;
   localparam logic [2:0] ADDR_C1_HI = 3'd5;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
   parameter int STAGES   = 2,
   parameter bit EDGE_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pin};
   end

   if (EDGE_OUT) begin : g_fall
      logic last_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) last_q <= 1'b0;
         else        last_q <= chain_q[STAGES-1];
      end
      assign q = last_q & ~chain_q[STAGES-1];

      // one event per falling edge: the pulse never lasts two cycles
      assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
         q |=> !q);
   end else begin : g_level
      assign q = chain_q[STAGES-1];
   end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int W        = 8,
   parameter int PRE_W    = 5,
   parameter bit SPLIT_EN = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  tmr_cfg_t     cfg,
   input  logic         run,
   input  logic         gate_lvl,
   input  logic         ev_fall,
   input  logic         tick_en,
   input  logic         aux_run,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] cnt_lo,
   output logic [W-1:0] cnt_hi,
   output logic         ovf_main,
   output logic         ovf_aux
);

   localparam int C13_W = W + PRE_W;
   localparam int C16_W = 2 * W;

   if (PRE_W < 1 || PRE_W >= W) begin : g_bad_pre
      $error("tmr_channel: PRE_W must lie in 1..W-1");
   end

   logic             qualify;
   logic             src;
   logic             inc;
   logic [C13_W-1:0] c13_inc;
   logic [C16_W-1:0] c16_inc;
   logic [W-1:0]     nxt_lo;
   logic [W-1:0]     nxt_hi;

   assign qualify = run & (~cfg.gate | gate_lvl);
   assign src     = cfg.ext_src ? ev_fall : tick_en;
   assign inc     = qualify & src;
   assign c13_inc = {cnt_hi, cnt_lo[PRE_W-1:0]} + 1'b1;
   assign c16_inc = {cnt_hi, cnt_lo} + 1'b1;

   always_comb begin
      nxt_lo   = cnt_lo;
      nxt_hi   = cnt_hi;
      ovf_main = 1'b0;
      ovf_aux  = 1'b0;
      case (cfg.mode)
         MODE_13: if (inc) begin
            nxt_hi   = c13_inc[C13_W-1:PRE_W];
            nxt_lo   = {cnt_lo[W-1:PRE_W], c13_inc[PRE_W-1:0]};
            ovf_main = &{cnt_hi, cnt_lo[PRE_W-1:0]};
         end
         MODE_16: if (inc) begin
            {nxt_hi, nxt_lo} = c16_inc;
            ovf_main         = &{cnt_hi, cnt_lo};
         end
         MODE_RELOAD: if (inc) begin
            if (&cnt_lo) begin
               nxt_lo   = cnt_hi;
               ovf_main = 1'b1;
            end else begin
               nxt_lo = cnt_lo + 1'b1;
            end
         end
         MODE_SPLIT: if (SPLIT_EN) begin
            if (inc) begin
               nxt_lo   = cnt_lo + 1'b1;
               ovf_main = &cnt_lo;
            end
            if (aux_run && tick_en) begin
               nxt_hi  = cnt_hi + 1'b1;
               ovf_aux = &cnt_hi;
            end
         end
         default: ;
      endcase
      if (wr_lo) nxt_lo = wdata;
      if (wr_hi) nxt_hi = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else begin
         cnt_lo <= nxt_lo;
         cnt_hi <= nxt_hi;
      end
   end

   assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_lo && !wr_hi && cfg.mode != MODE_SPLIT)
      |=> ($stable(cnt_lo) && $stable(cnt_hi)));

   assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.gate && !gate_lvl && !wr_lo && !wr_hi && cfg.mode != MODE_SPLIT)
      |=> ($stable(cnt_lo) && $stable(cnt_hi)));

   assert_noedge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.ext_src && !ev_fall && !wr_lo && !wr_hi && cfg.mode == MODE_16)
      |=> ($stable(cnt_lo) && $stable(cnt_hi)));

   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == MODE_RELOAD && ovf_main && !wr_lo)
      |=> (cnt_lo == $past(cnt_hi)));

   if (!SPLIT_EN) begin : g_hold_chk
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg.mode == MODE_SPLIT && !wr_lo && !wr_hi)
         |=> ($stable(cnt_lo) && $stable(cnt_hi)));
   end

endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
   import tmr_pkg::*;
#(
   parameter int W           = 8,
   parameter int PRE_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  logic [1:0]   ev_pin,
   input  logic [1:0]   gate_pin,
   input  logic [1:0]   irq_ack,
   input  logic [2:0]   reg_addr,
   input  logic         reg_wr,
   input  logic [W-1:0] reg_wdata,
   output logic [W-1:0] reg_rdata,
   output logic [1:0]   ovf_flag
);

   localparam int NCH      = 2;
   localparam int MODE_W   = NCH * CFG_W;
   localparam int RUN_BIT0 = 4;

   if (W < MODE_W) begin : g_bad_w
      $error("dual_timer_counter: W must hold the configuration byte");
   end

   logic [MODE_W-1:0] mode_q;
   logic [NCH-1:0]    run_q;
   logic [NCH-1:0]    flag_q;
   logic [NCH-1:0]    ovf_main;
   logic [NCH-1:0]    ovf_aux;
   logic [NCH-1:0]    hw_set;
   logic [W-1:0]      cnt_lo [NCH];
   logic [W-1:0]      cnt_hi [NCH];
   logic              wr_mode;
   logic              wr_ctrl;

   assign wr_mode = reg_wr && (reg_addr == ADDR_MODE);
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (wr_mode) mode_q <= reg_wdata[MODE_W-1:0];
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic [2:0] LO_ADDR = ADDR_C0_LO + 3'(2 * g);
      localparam logic [2:0] HI_ADDR = ADDR_C0_HI + 3'(2 * g);
      localparam int RUN_POS  = RUN_BIT0 + 2 * g;
      localparam int FLAG_POS = RUN_POS + 1;

      tmr_cfg_t cfg;
      logic     gate_lvl;
      logic     ev_fall;

      assign cfg       = tmr_cfg_t'(mode_q[CFG_W*g +: CFG_W]);
      // a split channel borrows the flag of the other channel
      assign hw_set[g] = ovf_main[g] | ovf_aux[NCH-1-g];

      tmr_pin_sync #(.STAGES(SYNC_STAGES), .EDGE_OUT(1'b1)) u_ev_sync (
         .clk(clk), .rst_n(rst_n), .pin(ev_pin[g]), .q(ev_fall));

      tmr_pin_sync #(.STAGES(SYNC_STAGES), .EDGE_OUT(1'b0)) u_gate_sync (
         .clk(clk), .rst_n(rst_n), .pin(gate_pin[g]), .q(gate_lvl));

      tmr_channel #(.W(W), .PRE_W(PRE_W), .SPLIT_EN(g == 0)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg      (cfg),
         .run      (run_q[g]),
         .gate_lvl (gate_lvl),
         .ev_fall  (ev_fall),
         .tick_en  (tick_en),
         .aux_run  (run_q[NCH-1-g]),
         .wr_lo    (reg_wr && reg_addr == LO_ADDR),
         .wr_hi    (reg_wr && reg_addr == HI_ADDR),
         .wdata    (reg_wdata),
         .cnt_lo   (cnt_lo[g]),
         .cnt_hi   (cnt_hi[g]),
         .ovf_main (ovf_main[g]),
         .ovf_aux  (ovf_aux[g]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q[g]  <= 1'b0;
            flag_q[g] <= 1'b0;
         end else begin
            if (wr_ctrl) run_q[g] <= reg_wdata[RUN_POS];
            if (hw_set[g])       flag_q[g] <= 1'b1;
            else if (irq_ack[g]) flag_q[g] <= 1'b0;
            else if (wr_ctrl)    flag_q[g] <= reg_wdata[FLAG_POS];
         end
      end

      assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
         hw_set[g] |=> ovf_flag[g]);

      assert_ack_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_ack[g] && !hw_set[g]) |=> !ovf_flag[g]);

      assert_sw_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_ctrl && !irq_ack[g] && !hw_set[g])
         |=> (ovf_flag[g] == $past(reg_wdata[FLAG_POS])));
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_MODE:  reg_rdata = W'(mode_q);
         ADDR_CTRL:  reg_rdata = W'({flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000});
         ADDR_C0_LO: reg_rdata = cnt_lo[0];
         ADDR_C0_HI: reg_rdata = cnt_hi[0];
         ADDR_C1_LO: reg_rdata = cnt_lo[1];
         ADDR_C1_HI: reg_rdata = cnt_hi[1];
         default:    reg_rdata = '0;
      endcase
   end

   assign ovf_flag = flag_q;

endmodule

// File: tb/dual_timer_counter_tb_top.sv
module dual_timer_counter_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [1:0] ev_pin = 2'b11;
   logic [1:0] gate_pin = 2'b00;
   logic [1:0] irq_ack = 2'b00;
   logic [2:0] reg_addr = 3'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [1:0] ovf_flag;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   dual_timer_counter dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ev_pin(ev_pin),
      .gate_pin(gate_pin), .irq_ack(irq_ack), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ovf_flag(ovf_flag));

   // {mode nibble, lo, hi, ticks, exp lo, exp hi, exp flags}
   localparam logic [47:0] VECS [8] = '{
      48'h1_FE_FF_03_01_00_1,
      48'h1_34_12_05_39_12_0,
      48'h1_FF_00_01_00_01_0,
      48'h0_FE_FF_02_E0_00_1,
      48'h0_1F_00_01_00_01_0,
      48'h2_FD_F0_04_F1_F0_1,
      48'h2_20_10_03_23_10_0,
      48'h3_FE_55_02_00_55_1
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   function automatic string mode_tag(input logic [1:0] m);
      case (m)
         2'd0: return "R4 mode0";
         2'd1: return "R3 mode1";
         2'd2: return "R5 mode2";
         default: return "R6 split";
      endcase
   endfunction

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         check("R1 reset register", v, 8'h00);
      end
      check("R1 reset flags", {6'b0, ovf_flag}, 8'h00);

      // R2: register map behaviour
      wr(3'd1, 8'h0F);
      rd(3'd1, v);
      check("R2 ctrl low bits read zero", v, 8'h00);
      wr(3'd0, 8'hA5);
      rd(3'd0, v);
      check("R2 config readback", v, 8'hA5);

      // table of mode vectors on channel 0
      for (int i = 0; i < 8; i++) begin
         wr(3'd1, 8'h00);
         wr(3'd0, {4'h0, VECS[i][47:44]});
         wr(3'd2, VECS[i][43:36]);
         wr(3'd3, VECS[i][35:28]);
         wr(3'd1, 8'h10);
         ticks(int'(VECS[i][27:20]));
         rd(3'd2, v);
         check(mode_tag(VECS[i][45:44]), v, VECS[i][19:12]);
         rd(3'd3, v);
         check(mode_tag(VECS[i][45:44]), v, VECS[i][11:4]);
         check(mode_tag(VECS[i][45:44]), {6'b0, ovf_flag}, {4'h0, VECS[i][3:0]});
      end

      // R8: halt keeps count, resume continues
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h01);
      wr(3'd2, 8'h10);
      wr(3'd3, 8'h00);
      wr(3'd1, 8'h10);
      ticks(4);
      rd(3'd2, v);
      check("R8 counting", v, 8'h14);
      wr(3'd1, 8'h00);
      ticks(4);
      rd(3'd2, v);
      check("R8 halted holds", v, 8'h14);
      wr(3'd1, 8'h10);
      ticks(1);
      rd(3'd2, v);
      check("R8 resume", v, 8'h15);

      // R9: gate qualifier
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h09);
      wr(3'd2, 8'h00);
      gate_pin = 2'b00;
      wr(3'd1, 8'h10);
      ticks(5);
      rd(3'd2, v);
      check("R9 gate low blocks", v, 8'h00);
      gate_pin = 2'b01;
      repeat (4) @(negedge clk);
      ticks(3);
      rd(3'd2, v);
      check("R9 gate high counts", v, 8'h03);
      gate_pin = 2'b00;

      // R10: event pin counting, ticks ignored
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h05);
      wr(3'd2, 8'h00);
      wr(3'd1, 8'h10);
      @(negedge clk);
      tick_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         repeat (4) @(negedge clk);
         ev_pin[0] = 1'b0;
         repeat (4) @(negedge clk);
         ev_pin[0] = 1'b1;
      end
      repeat (6) @(negedge clk);
      tick_en = 1'b0;
      rd(3'd2, v);
      check("R10 falling edges counted", v, 8'h03);

      // R13 then R11
      wr(3'd1, 8'hA0);
      check("R13 software sets flags", {6'b0, ovf_flag}, 8'h03);
      @(negedge clk); irq_ack = 2'b01;
      @(negedge clk); irq_ack = 2'b00;
      check("R11 ack ch0 only", {6'b0, ovf_flag}, 8'h02);
      @(negedge clk); irq_ack = 2'b10;
      @(negedge clk); irq_ack = 2'b00;
      check("R11 ack ch1", {6'b0, ovf_flag}, 8'h00);

      // R12: wrap beats software clear and ack
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h02);
      wr(3'd2, 8'hFF);
      wr(3'd3, 8'h07);
      wr(3'd1, 8'h10);
      @(negedge clk);
      tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h10;
      @(negedge clk);
      tick_en = 1'b0; reg_wr = 1'b0;
      check("R12 wrap beats write", {6'b0, ovf_flag}, 8'h01);
      rd(3'd2, v);
      check("R5 reload value", v, 8'h07);
      wr(3'd1, 8'h10);
      wr(3'd2, 8'hFF);
      @(negedge clk);
      tick_en = 1'b1; irq_ack = 2'b01;
      @(negedge clk);
      tick_en = 1'b0; irq_ack = 2'b00;
      check("R12 wrap beats ack", {6'b0, ovf_flag}, 8'h01);

      // R7: channel 1 mode 3 freezes
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h30);
      wr(3'd4, 8'h44);
      wr(3'd5, 8'h22);
      wr(3'd1, 8'h40);
      ticks(5);
      rd(3'd4, v);
      rd(3'd5, v2);
      check("R7 ch1 lo frozen", v, 8'h44);
      check("R7 ch1 hi frozen", v2, 8'h22);

      // R6: split high byte under channel 1 run
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h03);
      wr(3'd2, 8'h00);
      wr(3'd3, 8'hFE);
      wr(3'd1, 8'h40);
      ticks(3);
      rd(3'd3, v);
      rd(3'd2, v2);
      check("R6 split hi counts", v, 8'h01);
      check("R6 split lo idle", v2, 8'h00);
      check("R6 split hi sets ch1 flag", {6'b0, ovf_flag}, 8'h02);

      // R3 on channel 1
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h10);
      wr(3'd4, 8'hFF);
      wr(3'd5, 8'hFF);
      wr(3'd1, 8'h40);
      ticks(1);
      rd(3'd4, v);
      check("R3 ch1 wrap lo", v, 8'h00);
      check("R3 ch1 flag", {6'b0, ovf_flag}, 8'h02);

      // R2: byte write wins over same-cycle count
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h01);
      wr(3'd2, 8'h05);
      wr(3'd3, 8'h09);
      wr(3'd1, 8'h10);
      @(negedge clk);
      tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h80;
      @(negedge clk);
      tick_en = 1'b0; reg_wr = 1'b0;
      rd(3'd2, v);
      check("R2 write wins lo", v, 8'h80);
      rd(3'd3, v);
      check("R2 hi untouched", v, 8'h09);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule